// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block is a bus master that moves bytes between a table of configuration items and system memory. Software places a 16-byte descriptor in memory and writes the descriptor's 64-bit address into an 8-byte register window. Writing the low half of the address starts a run, and so does a single 64-bit write. The engine then fetches the descriptor, optionally selects a new item, and performs one operation for the requested length. The operation is a read (item to memory), a write (memory to item) or a skip (advance the item offset). At the end the engine writes a status word back over the descriptor's control field.

Reads of the window return a fixed 64-bit signature, so software can check that the engine is present. The memory side is a byte-wide request/acknowledge port that can flag an error on any access. The item table sits outside this block and is shared with the plain read port. The engine keeps the current item key and byte offset. The table supplies each item's length, data byte, presence flag and writable flag.

Top module: `cfg_dma_engine`

## Requirements
- R1: A 4-byte write at window offset 0 loads the high 32 address bits and clears the low 32 bits. A 4-byte write at offset 4 ORs data[31:0] into the low bits and starts a run. An 8-byte write at offset 0 loads the full address and starts a run. Any other write size or offset has no effect.
- R2: Starting a run clears the stored address. A later write at offset 4 alone therefore fetches from an address whose high 32 bits are zero.
- R3: A read of size S (1..8) at offset A returns bytes A..A+S-1 of the constant 0x51454D5520434647, right-aligned. Byte 0 is 0x51 and byte A lands in the most significant returned byte. The result is zero when A+S exceeds 8. Reads have no side effect.
- R4: The descriptor is read as 16 byte accesses at ascending addresses. Bytes 0-3 hold the control word, bytes 4-7 the length and bytes 8-15 the target address, each big-endian. A successful run makes exactly 16 fetch accesses, one access per transferred memory byte, and 4 status accesses.
- R5: In the control word, bit 1 requests a read, bit 4 a write and bit 2 a skip. If more than one is set, read wins over write, and write wins over skip. With none set, no data moves and the run succeeds.
- R6: When control bit 3 is set, the key becomes control[31:16] and the offset becomes 0 before the transfer. Otherwise the key and offset carry over from the previous run. After reset the key is 0 and the offset is 0.
- R7: A read copies item bytes from the current offset to ascending target addresses. Once past the end of the item, or when the item is absent, it writes zero bytes instead.
- R8: A write copies memory bytes into the item only while the item is present, writable and within its length. Reaching the end or a read-only item sets the error status and ends the run. Bytes already written stay written.
- R9: A skip inside the item advances the offset with no memory access. Past the end, or on an absent item, a skip consumes the remaining length with no memory access.
- R10: A memory error during the descriptor fetch or the transfer ends the run with error status.
- R11: At completion the engine writes 4 bytes at the descriptor address: 00 00 00 00 on success, 00 00 00 01 on error.
- R12: busy_o rises in the cycle after the starting write and stays high until the last status byte is acknowledged. Window writes while busy are ignored.
- R13: After reset busy_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Window write strobe |
| reg_addr_i | input | 3 | Window byte offset |
| reg_size_i | input | 4 | Access size in bytes |
| reg_wdata_i | input | 64 | Write data, right-aligned |
| reg_rdata_o | output | 64 | Signature read data |
| busy_o | output | 1 | Run in progress |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid with acknowledge |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_err_i | input | 1 | Access failed, valid with acknowledge |
| itm_key_o | output | 16 | Current item key |
| itm_off_o | output | 32 | Current byte offset within the item |
| itm_we_o | output | 1 | Item byte write strobe |
| itm_wdata_o | output | 8 | Item write byte |
| itm_rdata_i | input | 8 | Item byte at the current offset |
| itm_len_i | input | 32 | Length of the current item |
| itm_hit_i | input | 1 | Current key names a present item |
| itm_wr_ok_i | input | 1 | Current item accepts writes |

## Verification
Random read descriptors are driven with random keys (including an absent one), random lengths that are shorter than, equal to or longer than the item, and random acknowledge delays. These runs separate correct clipping and zero padding from overruns and off-by-one errors at the item end. Directed runs follow a read without select after a read or a skip, which tells a carried-over offset from a reset one. Writes are aimed at a read-only item and past the end of a writable item, and control words with several operation bits set expose the priority order. Error addresses at the descriptor and at the target, plus split and full address writes made before, during and after a run, separate the trigger, clear and ignore rules. Counting memory accesses shows that a skip issues no traffic.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int AW = 64;
  localparam int LW = 32;
  localparam int KW = 16;
  localparam int BW = 8;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam int CW = $clog2(DESC_BYTES);
  localparam logic [63:0] SIGNATURE = 64'h51454D5520434647;

  localparam int CB_RD   = 1;
  localparam int CB_SKIP = 2;
  localparam int CB_SEL  = 3;
  localparam int CB_WR   = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_DECODE, ST_XFER, ST_STAT} st_e;
  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR, OP_SKIP} op_e;

  typedef struct packed {
    logic [LW-1:0] ctl;
    logic [LW-1:0] len;
    logic [AW-1:0] tgt;
  } desc_t;
endpackage

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs
  import cfg_dma_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    addr_i,
  input  logic [3:0]    size_i,
  input  logic [63:0]   wdata_i,
  input  logic          busy_i,
  output logic [63:0]   rdata_o,
  output logic          trig_o,
  output logic [AW-1:0] trig_addr_o
);
  logic [AW-1:0] ptr_q;
  logic wr_hi, wr_lo, wr_full;

  assign wr_hi   = wr_i && !busy_i && size_i == 4'd4 && addr_i == 3'd0;
  assign wr_lo   = wr_i && !busy_i && size_i == 4'd4 && addr_i == 3'd4;
  assign wr_full = wr_i && !busy_i && size_i == 4'd8 && addr_i == 3'd0;
  assign trig_o  = wr_lo || wr_full;
  assign trig_addr_o = wr_full ? wdata_i : (ptr_q | {32'h0, wdata_i[31:0]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (wr_hi)  ptr_q <= {wdata_i[31:0], 32'h0};
    else if (trig_o) ptr_q <= '0;
  end

  function automatic logic [7:0] sig_byte(int j);
    return 8'(SIGNATURE >> (8 * (7 - j)));
  endfunction

  always_comb begin
    rdata_o = '0;
    if (size_i != 4'd0 && (int'(addr_i) + int'(size_i)) <= 8) begin
      for (int b = 0; b < 8; b++)
        if (b < int'(size_i))
          rdata_o[8*b +: 8] = sig_byte(int'(addr_i) + int'(size_i) - 1 - b);
    end
  end

  p_ptr_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> ptr_q == '0);
  p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ptr_q));
endmodule

// File: rtl/cfg_dma_core.sv
module cfg_dma_core
  import cfg_dma_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [AW-1:0] trig_addr_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_wdata_o,
  input  logic [BW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic [KW-1:0] itm_key_o,
  output logic [LW-1:0] itm_off_o,
  output logic          itm_we_o,
  output logic [BW-1:0] itm_wdata_o,
  input  logic [BW-1:0] itm_rdata_i,
  input  logic [LW-1:0] itm_len_i,
  input  logic          itm_hit_i,
  input  logic          itm_wr_ok_i
);
  st_e           st_q;
  op_e           op_q, op_d;
  desc_t         desc_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] dbase_q, tgt_q;
  logic [KW-1:0] key_q;
  logic [LW-1:0] off_q, rem_q;
  logic          err_q;
  logic          in_rng, wr_ok, last;
  logic          unused_ctl;

  assign unused_ctl = ^{desc_q.ctl[15:5], desc_q.ctl[0]};
  assign in_rng = itm_hit_i && (off_q < itm_len_i);
  assign wr_ok  = in_rng && itm_wr_ok_i;
  assign last   = rem_q == LW'(1);
  assign busy_o = st_q != ST_IDLE;
  assign itm_key_o   = key_q;
  assign itm_off_o   = off_q;
  assign itm_wdata_o = mem_rdata_i;
  assign itm_we_o    = st_q == ST_XFER && op_q == OP_WR && wr_ok && mem_ack_i && !mem_err_i;

  // read wins over write, write over skip
  always_comb begin
    if (desc_q.ctl[CB_RD])        op_d = OP_RD;
    else if (desc_q.ctl[CB_WR])   op_d = OP_WR;
    else if (desc_q.ctl[CB_SKIP]) op_d = OP_SKIP;
    else                          op_d = OP_NONE;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = dbase_q + AW'(cnt_q);
    mem_wdata_o = '0;
    unique case (st_q)
      ST_FETCH: mem_req_o = 1'b1;
      ST_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = (cnt_q == CW'(STAT_BYTES - 1)) ? BW'(err_q) : '0;
      end
      ST_XFER: begin
        mem_addr_o = tgt_q;
        if (op_q == OP_RD) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_wdata_o = in_rng ? itm_rdata_i : '0;
        end else if (op_q == OP_WR) begin
          mem_req_o = wr_ok;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      desc_q  <= '0;
      cnt_q   <= '0;
      dbase_q <= '0;
      tgt_q   <= '0;
      key_q   <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trig_i) begin
          dbase_q <= trig_addr_i;
          cnt_q   <= '0;
          err_q   <= 1'b0;
          st_q    <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack_i) begin
          if (mem_err_i) begin
            err_q <= 1'b1;
            cnt_q <= '0;
            st_q  <= ST_STAT;
          end else begin
            desc_q <= {desc_q[$bits(desc_t)-BW-1:0], mem_rdata_i};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CW'(DESC_BYTES - 1)) st_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (desc_q.ctl[CB_SEL]) begin
            key_q <= desc_q.ctl[LW-1 -: KW];
            off_q <= '0;
          end
          op_q  <= op_d;
          rem_q <= desc_q.len;
          tgt_q <= desc_q.tgt;
          cnt_q <= '0;
          st_q  <= (op_d == OP_NONE || desc_q.len == '0) ? ST_STAT : ST_XFER;
        end
        ST_XFER: begin
          unique case (op_q)
            OP_RD: if (mem_ack_i) begin
              if (mem_err_i) begin
                err_q <= 1'b1;
                st_q  <= ST_STAT;
              end else begin
                off_q <= off_q + LW'(in_rng);
                tgt_q <= tgt_q + 1'b1;
                rem_q <= rem_q - 1'b1;
                if (last) st_q <= ST_STAT;
              end
            end
            OP_WR: begin
              if (!wr_ok) begin
                err_q <= 1'b1;
                st_q  <= ST_STAT;
              end else if (mem_ack_i) begin
                if (mem_err_i) begin
                  err_q <= 1'b1;
                  st_q  <= ST_STAT;
                end else begin
                  off_q <= off_q + 1'b1;
                  tgt_q <= tgt_q + 1'b1;
                  rem_q <= rem_q - 1'b1;
                  if (last) st_q <= ST_STAT;
                end
              end
            end
            OP_SKIP: begin
              if (in_rng) begin
                off_q <= off_q + 1'b1;
                tgt_q <= tgt_q + 1'b1;
                rem_q <= rem_q - 1'b1;
                if (last) st_q <= ST_STAT;
              end else begin
                rem_q <= '0;
                st_q  <= ST_STAT;
              end
            end
            default: st_q <= ST_STAT;
          endcase
        end
        ST_STAT: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(STAT_BYTES - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  p_itm_we_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itm_we_o |-> itm_wr_ok_i && itm_hit_i && (itm_off_o < itm_len_i));
  p_skip_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER && op_q == OP_SKIP) |-> !mem_req_o);
  p_end_on_stat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_ack_i && mem_we_o));
  p_rem_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER && $past(st_q == ST_XFER)) |-> rem_q <= $past(rem_q));
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [3:0]    reg_size_i,
  input  logic [63:0]   reg_wdata_i,
  output logic [63:0]   reg_rdata_o,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_wdata_o,
  input  logic [BW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic [KW-1:0] itm_key_o,
  output logic [LW-1:0] itm_off_o,
  output logic          itm_we_o,
  output logic [BW-1:0] itm_wdata_o,
  input  logic [BW-1:0] itm_rdata_i,
  input  logic [LW-1:0] itm_len_i,
  input  logic          itm_hit_i,
  input  logic          itm_wr_ok_i
);
  logic          trig;
  logic [AW-1:0] trig_addr;

  cfg_dma_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .size_i      (reg_size_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy_o),
    .rdata_o     (reg_rdata_o),
    .trig_o      (trig),
    .trig_addr_o (trig_addr)
  );

  cfg_dma_core u_core (
    .clk_i, .rst_ni,
    .trig_i      (trig),
    .trig_addr_i (trig_addr),
    .busy_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ack_i, .mem_err_i,
    .itm_key_o, .itm_off_o, .itm_we_o, .itm_wdata_o,
    .itm_rdata_i, .itm_len_i, .itm_hit_i, .itm_wr_ok_i
  );
endmodule

// File: tb/tb_cfg_dma_engine.sv
module tb_cfg_dma_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [3:0]  reg_size = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        busy, mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic [15:0] itm_key;
  logic [31:0] itm_off, itm_len;
  logic        itm_we, itm_hit, itm_wr_ok;
  logic [7:0]  itm_wdata, itm_rdata;

  logic [7:0]  mem [0:1023];
  logic [7:0]  it2 [0:5];
  int          checks = 0, fails = 0, ack_cnt = 0;
  logic [63:0] first_addr = '0;

  localparam logic [31:0] C_RD = 32'h02, C_SK = 32'h04, C_SEL = 32'h08, C_WR = 32'h10;

  always #10 clk = ~clk;

  cfg_dma_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_size_i(reg_size),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err),
    .itm_key_o(itm_key), .itm_off_o(itm_off), .itm_we_o(itm_we),
    .itm_wdata_o(itm_wdata), .itm_rdata_i(itm_rdata), .itm_len_i(itm_len),
    .itm_hit_i(itm_hit), .itm_wr_ok_i(itm_wr_ok)
  );

  function automatic int it_len(int k);
    case (k)
      0: return 4;
      1: return 8;
      2: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] rom_byte(int k, int i);
    if (k == 0) return 8'(64'h51454D55 >> (8 * (3 - i)));
    if (k == 1) return 8'(8'h10 + i);
    return 8'h00;
  endfunction

  function automatic logic [63:0] sig_exp(int a, int s);
    logic [63:0] v = '0;
    if (s == 0 || a + s > 8) return '0;
    for (int b = 0; b < s; b++)
      v[8*b +: 8] = 8'(64'h51454D5520434647 >> (8 * (7 - (a + s - 1 - b))));
    return v;
  endfunction

  assign itm_hit   = itm_key < 16'd4;
  assign itm_len   = 32'(it_len(int'(itm_key)));
  assign itm_wr_ok = itm_key == 16'd2;
  assign itm_rdata = (itm_key == 16'd2 && itm_off < 32'd6) ? it2[itm_off[2:0]]
                   : rom_byte(int'(itm_key), int'(itm_off));

  always @(posedge clk) if (itm_we) it2[itm_off[2:0]] <= itm_wdata;

  // memory responder: addresses of 1024 and above fail
  always @(negedge clk) begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    if (rst_n && mem_req && ($urandom % 4 != 0)) begin
      mem_ack = 1'b1;
      ack_cnt++;
      if (ack_cnt == 1) first_addr = mem_addr;
      if (mem_addr >= 64'd1024) mem_err = 1'b1;
      else if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
      else mem_rdata = mem[mem_addr[9:0]];
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr_t(int a, int s, logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_size = 4'(s); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_rd_t(int a, int s, output logic [63:0] v);
    @(negedge clk);
    reg_addr = 3'(a); reg_size = 4'(s);
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic go(int base);
    ack_cnt = 0;
    reg_wr_t(0, 8, 64'(base));
    wait_idle();
  endtask

  task automatic put_desc(int b, logic [31:0] ctl, logic [31:0] len, logic [63:0] tgt);
    for (int i = 0; i < 4; i++) mem[b+i]   = ctl[31-8*i -: 8];
    for (int i = 0; i < 4; i++) mem[b+4+i] = len[31-8*i -: 8];
    for (int i = 0; i < 8; i++) mem[b+8+i] = tgt[63-8*i -: 8];
  endtask

  function automatic logic [31:0] stat(int b);
    return {mem[b], mem[b+1], mem[b+2], mem[b+3]};
  endfunction

  function automatic logic [31:0] selk(int k);
    return {16'(k), 16'h0} | C_SEL;
  endfunction

  function automatic logic [63:0] get_bytes(int b, int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[55:0], mem[b+i]};
    return v;
  endfunction

  task automatic fill(int b, int n, logic [7:0] v);
    for (int i = 0; i < n; i++) mem[b+i] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 6; i++) it2[i] = 8'hA0 + 8'(i);
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(busy == 1'b0 && mem_req == 1'b0, "R13 reset idle", {busy, mem_req}, 0);
    rst_n = 1'b1;

    // R13 + R6: key 0 offset 0 after reset, read without select
    put_desc(0, C_RD, 4, 64'h100);
    go(0);
    chk(get_bytes(32'h100, 4) == 64'h51454D55, "R13 default key0", get_bytes(32'h100, 4), 64'h51454D55);
    chk(stat(0) == 0, "R11 success status", stat(0), 0);
    chk(ack_cnt == 24 && first_addr == 0, "R4 access count", 64'(ack_cnt), 24);

    // R3 signature reads
    reg_rd_t(0, 8, v); chk(v == 64'h51454D5520434647, "R3 full", v, 64'h51454D5520434647);
    reg_rd_t(4, 4, v); chk(v == 64'h20434647, "R3 low word", v, 64'h20434647);
    reg_rd_t(2, 1, v); chk(v == 64'h4D, "R3 byte2", v, 64'h4D);
    reg_rd_t(6, 4, v); chk(v == 0, "R3 overrun", v, 0);
    for (int i = 0; i < 10; i++) begin
      int a = int'($urandom % 8);
      int s = 1 + int'($urandom % 8);
      reg_rd_t(a, s, v);
      chk(v == sig_exp(a, s), "R3 random", v, sig_exp(a, s));
    end
    chk(busy == 1'b0, "R3 no side effect", busy, 0);

    // R6 offset carry-over
    put_desc(32'h20, selk(1) | C_RD, 3, 64'h110);
    go(32'h20);
    put_desc(32'h40, C_RD, 3, 64'h118);
    go(32'h40);
    chk(get_bytes(32'h110, 3) == 64'h101112 && get_bytes(32'h118, 3) == 64'h131415,
        "R6 carry offset", get_bytes(32'h118, 3), 64'h131415);

    // R9 skip in range, no memory traffic
    put_desc(32'h20, selk(1) | C_SK, 5, 64'h120);
    go(32'h20);
    chk(ack_cnt == 20 && stat(32'h20) == 0, "R9 skip quiet", 64'(ack_cnt), 20);
    put_desc(32'h40, C_RD, 3, 64'h128);
    go(32'h40);
    chk(get_bytes(32'h128, 3) == 64'h151617, "R9 skip advanced", get_bytes(32'h128, 3), 64'h151617);
    // R9 skip past end, R7 zero fill afterwards
    put_desc(32'h20, selk(1) | C_SK, 20, 64'h130);
    go(32'h20);
    chk(ack_cnt == 20 && stat(32'h20) == 0, "R9 skip past end", 64'(ack_cnt), 20);
    fill(32'h130, 4, 8'hEE);
    put_desc(32'h40, C_RD, 2, 64'h130);
    go(32'h40);
    chk(get_bytes(32'h130, 3) == 64'h0000EE, "R7 zeros after end", get_bytes(32'h130, 3), 64'h0000EE);

    // R7 clipping and absent item
    fill(32'h140, 8, 8'hEE);
    put_desc(32'h20, selk(0) | C_RD, 7, 64'h140);
    go(32'h20);
    chk(get_bytes(32'h140, 8) == 64'h51454D55000000EE, "R7 clip pad", get_bytes(32'h140, 8), 64'h51454D55000000EE);
    fill(32'h150, 4, 8'hEE);
    put_desc(32'h20, selk(4) | C_RD, 3, 64'h150);
    go(32'h20);
    chk(get_bytes(32'h150, 4) == 64'h000000EE && stat(32'h20) == 0, "R7 absent item", get_bytes(32'h150, 4), 64'h000000EE);

    // R8 writes
    mem[32'h180] = 8'hAA; mem[32'h181] = 8'hBB; mem[32'h182] = 8'hCC;
    put_desc(32'h20, selk(2) | C_WR, 3, 64'h180);
    go(32'h20);
    chk(stat(32'h20) == 0, "R8 write ok", stat(32'h20), 0);
    put_desc(32'h40, selk(2) | C_RD, 6, 64'h190);
    go(32'h40);
    chk(get_bytes(32'h190, 6) == 64'hAABBCCA3A4A5, "R8 item updated", get_bytes(32'h190, 6), 64'hAABBCCA3A4A5);
    put_desc(32'h20, selk(1) | C_WR, 2, 64'h180);
    go(32'h20);
    chk(stat(32'h20) == 1, "R8 read-only error", stat(32'h20), 1);
    put_desc(32'h40, selk(1) | C_RD, 2, 64'h198);
    go(32'h40);
    chk(get_bytes(32'h198, 2) == 64'h1011, "R8 read-only intact", get_bytes(32'h198, 2), 64'h1011);
    for (int i = 0; i < 8; i++) mem[32'h1A0 + i] = 8'h30 + 8'(i);
    put_desc(32'h20, selk(2) | C_WR, 8, 64'h1A0);
    go(32'h20);
    chk(stat(32'h20) == 1, "R8 write past end", stat(32'h20), 1);
    put_desc(32'h40, selk(2) | C_RD, 6, 64'h1B0);
    go(32'h40);
    chk(get_bytes(32'h1B0, 6) == 64'h303132333435, "R8 partial kept", get_bytes(32'h1B0, 6), 64'h303132333435);

    // R5 priority
    fill(32'h1C0, 2, 8'hEE);
    put_desc(32'h20, selk(1) | C_RD | C_WR | C_SK, 2, 64'h1C0);
    go(32'h20);
    chk(get_bytes(32'h1C0, 2) == 64'h1011 && stat(32'h20) == 0, "R5 read first", get_bytes(32'h1C0, 2), 64'h1011);
    mem[32'h1C8] = 8'h77; mem[32'h1C9] = 8'h88;
    put_desc(32'h20, selk(2) | C_WR | C_SK, 2, 64'h1C8);
    go(32'h20);
    put_desc(32'h40, selk(2) | C_RD, 2, 64'h1D0);
    go(32'h40);
    chk(get_bytes(32'h1D0, 2) == 64'h7788, "R5 write over skip", get_bytes(32'h1D0, 2), 64'h7788);
    put_desc(32'h20, selk(1), 5, 64'h1D8);
    go(32'h20);
    chk(ack_cnt == 20 && stat(32'h20) == 0, "R5 no operation", 64'(ack_cnt), 20);

    // R10 errors
    put_desc(32'h20, selk(1) | C_RD, 2, 64'h500);
    go(32'h20);
    chk(stat(32'h20) == 1 && ack_cnt == 21, "R10 target error", stat(32'h20), 1);
    go(32'h800);
    chk(ack_cnt == 5 && busy == 1'b0, "R10 fetch error", 64'(ack_cnt), 5);

    // R1 split address and ignored writes
    reg_wr_t(0, 4, 64'h1);
    @(negedge clk);
    chk(busy == 1'b0, "R1 high write no start", busy, 0);
    ack_cnt = 0;
    reg_wr_t(4, 4, 64'h0);
    wait_idle();
    chk(first_addr == 64'h1_0000_0000, "R1 split address", first_addr, 64'h1_0000_0000);
    reg_wr_t(0, 2, 64'h20);
    reg_wr_t(2, 4, 64'h20);
    @(negedge clk);
    chk(busy == 1'b0, "R1 bad size ignored", busy, 0);
    // R2 cleared after start
    put_desc(32'h60, selk(0) | C_RD, 1, 64'h1E0);
    ack_cnt = 0;
    reg_wr_t(4, 4, 64'h60);
    wait_idle();
    chk(first_addr == 64'h60 && stat(32'h60) == 0, "R2 high bits cleared", first_addr, 64'h60);

    // R12 busy span and writes ignored while busy
    put_desc(32'h20, selk(1) | C_RD, 4, 64'h1E8);
    ack_cnt = 0;
    reg_wr_t(0, 8, 64'h20);
    chk(busy == 1'b1, "R12 busy after start", busy, 1);
    reg_wr_t(0, 4, 64'hFF);
    reg_wr_t(0, 8, 64'h40);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && ack_cnt == 24, "R12 no restart", 64'(ack_cnt), 24);
    ack_cnt = 0;
    reg_wr_t(4, 4, 64'h60);
    wait_idle();
    chk(first_addr == 64'h60, "R12 busy write ignored", first_addr, 64'h60);

    // random reads: key, length and acknowledge timing
    for (int it = 0; it < 25; it++) begin
      int k = int'($urandom % 5);
      int n = int'($urandom % 13);
      logic ok = 1'b1;
      fill(32'h200, 16, 8'hEE);
      put_desc(32'h80, selk(k) | C_RD, 32'(n), 64'h200);
      go(32'h80);
      for (int i = 0; i < 16; i++) begin
        logic [7:0] e;
        if (i >= n) e = 8'hEE;
        else if (i < it_len(k)) e = (k == 2) ? it2[i] : rom_byte(k, i);
        else e = 8'h00;
        if (mem[32'h200 + i] != e) ok = 1'b0;
      end
      chk(ok && stat(32'h80) == 0, "R7 random read", get_bytes(32'h200, 8), 64'(k));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule